// File: doc/BRIEF.md
# Per-Thread Squash Request Merger

The execute stage of an out-of-order core can discover several reasons to flush the pipeline in one cycle. A branch resolves against its prediction, or a load turns out to have read memory before an older store to the same address wrote it. This block takes every such request raised in a cycle and keeps, for each hardware thread, the single request that reaches furthest back in program order. One clock later it hands the commit stage a per-thread squash bundle. The bundle holds a valid bit, the sequence number to squash from, the PC to refetch from, a flag that says whether the named instruction itself is flushed, and a flag that says the squash came from a mispredicted branch.

Requests arrive on two groups of slots. The branch slots carry the mispredicted branch's sequence number and its corrected target. The memory-ordering slots carry the sequence number and PC of the violating load, not of the store it conflicted with. Only the violator and younger work are thrown away, and the load is refetched from its own PC. Within a cycle the slots are evaluated in a fixed order: all branch slots by index, then all memory slots by index. A branch replaces the pending request only when it is strictly older. A memory violation also replaces a pending request of the same age. This makes a memory violation win a same-age tie, because the violator must itself be flushed.

Top module: `sqm_merger`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Outputs are registered with one cycle of latency and rebuilt every cycle. A thread with no request in cycle N shows all of its bundle fields as 0 after edge N+1.
- R3: Among the requests for one thread in a cycle, the one with the smallest sequence number wins.
- R4: A winning branch request gives valid=1, seq equal to the branch's sequence number, pc equal to the corrected target, include=0 and mispred=1.
- R5: A winning memory-violation request gives valid=1, seq equal to the violator's sequence number, pc equal to the violator's own PC unchanged, include=1 and mispred=0.
- R6: When a branch request and a memory-violation request for the same thread carry equal sequence numbers and are the oldest, the memory-violation request wins, whatever their slot indices.
- R7: Between two branch requests for a thread with equal and oldest sequence numbers, the lower-indexed branch slot wins.
- R8: Between two memory-violation requests for a thread with equal and oldest sequence numbers, the higher-indexed memory slot wins.
- R9: Thread ID k (field k of the tid bus, slot i at bits [i*TID_W +: TID_W]) selects bundle k only. A request on one thread never changes another thread's bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | NUM_BR | Branch mispredict request valid, one bit per slot |
| br_tid | input | NUM_BR*TID_W | Thread ID per branch slot |
| br_seq | input | NUM_BR*16 | Sequence number of the mispredicted branch |
| br_target | input | NUM_BR*32 | Corrected branch target |
| mv_valid | input | NUM_MV | Memory-ordering violation request valid, one bit per slot |
| mv_tid | input | NUM_MV*TID_W | Thread ID per violation slot |
| mv_seq | input | NUM_MV*16 | Sequence number of the violating load |
| mv_pc | input | NUM_MV*32 | PC of the violating load |
| sq_valid | output | NUM_THREADS | Squash valid per thread |
| sq_seq | output | NUM_THREADS*16 | Sequence number to squash from |
| sq_pc | output | NUM_THREADS*32 | Refetch PC |
| sq_include | output | NUM_THREADS | The named instruction itself is flushed |
| sq_mispred | output | NUM_THREADS | The squash comes from a mispredicted branch |

## Verification
The hardest situation to reach from the ports is a same-age tie: a branch and a memory violation, or two requests of one kind, that land on one thread with identical sequence numbers in the same cycle. That tie must also be the oldest, so that an even older request does not hide it. Directed cases place each kind of tie in both slot arrangements. The random phase then draws sequence numbers from a range of only eight values with every slot about half loaded, so that ties and mixed-age competitions between threads come up often.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

  parameter int SQ_SEQ_W = 16;
  parameter int SQ_PC_W  = 32;

  typedef logic [SQ_SEQ_W-1:0] sq_seq_t;
  typedef logic [SQ_PC_W-1:0]  sq_pc_t;

  typedef enum logic {
    SRC_BRANCH  = 1'b0,
    SRC_MEMVIOL = 1'b1
  } sq_src_e;

  typedef struct packed {
    logic    vld;
    sq_seq_t seq;
    sq_pc_t  pc;
    logic    incl;
    logic    mispred;
  } sq_bundle_t;

  // Decide whether a new request displaces what is pending for its thread.
  // Memory violations win ties, branches need to be strictly older.
  function automatic logic sq_replaces(input logic    pend_vld,
                                       input sq_seq_t pend_seq,
                                       input sq_seq_t new_seq,
                                       input sq_src_e src);
    if (!pend_vld)
      return 1'b1;
    if (src == SRC_MEMVIOL)
      return new_seq <= pend_seq;
    return new_seq < pend_seq;
  endfunction

  // Build the bundle a request produces if it wins.
  function automatic sq_bundle_t sq_make_bundle(input logic    vld,
                                                input sq_src_e src,
                                                input sq_seq_t seq,
                                                input sq_pc_t  pc);
    sq_bundle_t b;
    b.vld     = vld;
    b.seq     = seq;
    b.pc      = pc;
    b.incl    = (src == SRC_MEMVIOL);
    b.mispred = (src == SRC_BRANCH);
    return b;
  endfunction

endpackage

// File: rtl/sqm_slot_decode.sv
module sqm_slot_decode
  import sqm_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1,
  parameter bit IS_MEM      = 1'b0
) (
  input  logic                   vld_i,
  input  logic [TID_W-1:0]       tid_i,
  input  sq_seq_t                seq_i,
  input  sq_pc_t                 pc_i,
  output sq_bundle_t             cand_o,
  output logic [NUM_THREADS-1:0] hit_o
);

  localparam sq_src_e SRC = IS_MEM ? SRC_MEMVIOL : SRC_BRANCH;

  assign cand_o = sq_make_bundle(vld_i, SRC, seq_i, pc_i);

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++)
      hit_o[t] = vld_i && (tid_i == TID_W'(t));
  end

endmodule

// File: rtl/sqm_thread_pick.sv
module sqm_thread_pick
  import sqm_pkg::*;
#(
  parameter int NUM_BR = 2,
  parameter int NUM_MV = 2,
  localparam int NSLOT = NUM_BR + NUM_MV
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic       [NSLOT-1:0] hit_i,
  input  sq_bundle_t [NSLOT-1:0] cand_i,
  output sq_bundle_t             win_o
);

  function automatic sq_src_e slot_src(input int k);
    return (k >= NUM_BR) ? SRC_MEMVIOL : SRC_BRANCH;
  endfunction

  // Slots are applied in fixed order: branch slots, then memory slots.
  always_comb begin
    win_o = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (hit_i[k] && sq_replaces(win_o.vld, win_o.seq, cand_i[k].seq, slot_src(k)))
        win_o = cand_i[k];
    end
  end

  // Named events for the checks below
  logic any_req;
  assign any_req = |hit_i;

  // R2
  win_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req == win_o.vld);

  for (genvar k = 0; k < NSLOT; k++) begin : g_chk
    // R3
    win_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[k] |-> (win_o.seq <= cand_i[k].seq));
    if (k >= NUM_BR) begin : g_mem
      logic mem_at_win;
      assign mem_at_win = hit_i[k] && (cand_i[k].seq == win_o.seq);
      // R6
      mem_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_at_win |-> (win_o.incl && !win_o.mispred));
    end
  end

endmodule

// File: rtl/sqm_bundle_reg.sv
module sqm_bundle_reg
  import sqm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sq_bundle_t d_i,
  output sq_bundle_t q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_o <= '0;
    else
      q_o <= d_i;
  end

  // R5
  bundle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o.vld |-> (q_o.incl != q_o.mispred));

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_o.vld |-> (q_o == '0));

endmodule

// File: rtl/sqm_merger.sv
module sqm_merger
  import sqm_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_BR      = 2,
  parameter int NUM_MV      = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BR-1:0]               br_valid,
  input  logic [NUM_BR*TID_W-1:0]         br_tid,
  input  logic [NUM_BR*SQ_SEQ_W-1:0]      br_seq,
  input  logic [NUM_BR*SQ_PC_W-1:0]       br_target,
  input  logic [NUM_MV-1:0]               mv_valid,
  input  logic [NUM_MV*TID_W-1:0]         mv_tid,
  input  logic [NUM_MV*SQ_SEQ_W-1:0]      mv_seq,
  input  logic [NUM_MV*SQ_PC_W-1:0]       mv_pc,
  output logic [NUM_THREADS-1:0]          sq_valid,
  output logic [NUM_THREADS*SQ_SEQ_W-1:0] sq_seq,
  output logic [NUM_THREADS*SQ_PC_W-1:0]  sq_pc,
  output logic [NUM_THREADS-1:0]          sq_include,
  output logic [NUM_THREADS-1:0]          sq_mispred
);

  localparam int NSLOT = NUM_BR + NUM_MV;

  sq_bundle_t [NSLOT-1:0]                  cand;
  logic       [NSLOT-1:0][NUM_THREADS-1:0] hit;

  for (genvar k = 0; k < NUM_BR; k++) begin : g_br
    sqm_slot_decode #(
      .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .IS_MEM(1'b0)
    ) u_dec (
      .vld_i  (br_valid[k]),
      .tid_i  (br_tid[k*TID_W +: TID_W]),
      .seq_i  (br_seq[k*SQ_SEQ_W +: SQ_SEQ_W]),
      .pc_i   (br_target[k*SQ_PC_W +: SQ_PC_W]),
      .cand_o (cand[k]),
      .hit_o  (hit[k])
    );
  end

  for (genvar k = 0; k < NUM_MV; k++) begin : g_mv
    sqm_slot_decode #(
      .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .IS_MEM(1'b1)
    ) u_dec (
      .vld_i  (mv_valid[k]),
      .tid_i  (mv_tid[k*TID_W +: TID_W]),
      .seq_i  (mv_seq[k*SQ_SEQ_W +: SQ_SEQ_W]),
      .pc_i   (mv_pc[k*SQ_PC_W +: SQ_PC_W]),
      .cand_o (cand[NUM_BR+k]),
      .hit_o  (hit[NUM_BR+k])
    );
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [NSLOT-1:0] thr_hit;
    sq_bundle_t       win;
    sq_bundle_t       q;

    always_comb begin
      for (int k = 0; k < NSLOT; k++)
        thr_hit[k] = hit[k][t];
    end

    sqm_thread_pick #(.NUM_BR(NUM_BR), .NUM_MV(NUM_MV)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (thr_hit),
      .cand_i (cand),
      .win_o  (win)
    );

    sqm_bundle_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (win),
      .q_o   (q)
    );

    assign sq_valid[t]                        = q.vld;
    assign sq_seq[t*SQ_SEQ_W +: SQ_SEQ_W]     = q.seq;
    assign sq_pc[t*SQ_PC_W +: SQ_PC_W]        = q.pc;
    assign sq_include[t]                      = q.incl;
    assign sq_mispred[t]                      = q.mispred;
  end

endmodule

// File: tb/test_sqm_merger.sv
`timescale 1ns/1ps
module test_sqm_merger;

  localparam int NT = 2, NB = 2, NM = 2, TW = 1, SW = 16, PW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NB-1:0]    br_valid;
  logic [NB*TW-1:0] br_tid;
  logic [NB*SW-1:0] br_seq;
  logic [NB*PW-1:0] br_target;
  logic [NM-1:0]    mv_valid;
  logic [NM*TW-1:0] mv_tid;
  logic [NM*SW-1:0] mv_seq;
  logic [NM*PW-1:0] mv_pc;
  logic [NT-1:0]    sq_valid;
  logic [NT*SW-1:0] sq_seq;
  logic [NT*PW-1:0] sq_pc;
  logic [NT-1:0]    sq_include;
  logic [NT-1:0]    sq_mispred;

  sqm_merger i_sqm_merger (.*);

  logic          bv[NB]; logic [TW-1:0] bt[NB]; logic [SW-1:0] bs[NB]; logic [PW-1:0] bp[NB];
  logic          mv[NM]; logic [TW-1:0] mt[NM]; logic [SW-1:0] ms[NM]; logic [PW-1:0] mp[NM];

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      br_valid[k] = bv[k]; br_tid[k*TW +: TW] = bt[k];
      br_seq[k*SW +: SW] = bs[k]; br_target[k*PW +: PW] = bp[k];
    end
    for (int k = 0; k < NM; k++) begin
      mv_valid[k] = mv[k]; mv_tid[k*TW +: TW] = mt[k];
      mv_seq[k*SW +: SW] = ms[k]; mv_pc[k*PW +: PW] = mp[k];
    end
  end

  int n_cmp = 0, n_bad = 0;

  // Expected bundle: find oldest age, then prefer the last memory slot at
  // that age, otherwise the first branch slot at that age.
  function automatic void expect_thr(input int t, output logic ev, output logic [SW-1:0] es,
                                     output logic [PW-1:0] ep, output logic ei, output logic em);
    bit found = 0; logic [SW-1:0] oldest = '0; int mpick = -1; int bpick = -1;
    for (int k = 0; k < NB; k++)
      if (bv[k] && bt[k] == TW'(t) && (!found || bs[k] < oldest)) begin oldest = bs[k]; found = 1; end
    for (int k = 0; k < NM; k++)
      if (mv[k] && mt[k] == TW'(t) && (!found || ms[k] < oldest)) begin oldest = ms[k]; found = 1; end
    ev = 0; es = '0; ep = '0; ei = 0; em = 0;
    if (!found) return;
    for (int k = 0; k < NM; k++)
      if (mv[k] && mt[k] == TW'(t) && ms[k] == oldest) mpick = k;
    for (int k = NB-1; k >= 0; k--)
      if (bv[k] && bt[k] == TW'(t) && bs[k] == oldest) bpick = k;
    ev = 1; es = oldest;
    if (mpick >= 0) begin ep = mp[mpick]; ei = 1; end
    else begin ep = bp[bpick]; em = 1; end
  endfunction

  task automatic clear_reqs();
    for (int k = 0; k < NB; k++) begin bv[k] = 0; bt[k] = '0; bs[k] = '0; bp[k] = '0; end
    for (int k = 0; k < NM; k++) begin mv[k] = 0; mt[k] = '0; ms[k] = '0; mp[k] = '0; end
  endtask

  task automatic cmp_thr(input int t, input string tag, input logic ev, input logic [SW-1:0] es,
                         input logic [PW-1:0] ep, input logic ei, input logic em);
    logic [SW+PW+2:0] act, exp_v;
    act   = {sq_valid[t], sq_seq[t*SW +: SW], sq_pc[t*PW +: PW], sq_include[t], sq_mispred[t]};
    exp_v = {ev, es, ep, ei, em};
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s thread %0d: actual v=%b seq=%h pc=%h incl=%b misp=%b expected v=%b seq=%h pc=%h incl=%b misp=%b",
               tag, t, act[SW+PW+2], act[SW+PW+1:PW+2], act[PW+1:2], act[1], act[0],
               ev, es, ep, ei, em);
    end
  endtask

  // Inputs are set at a falling edge; the result is visible at the next one.
  task automatic step(input string tag);
    logic ev[NT]; logic [SW-1:0] es[NT]; logic [PW-1:0] ep[NT]; logic ei[NT]; logic em[NT];
    for (int t = 0; t < NT; t++) expect_thr(t, ev[t], es[t], ep[t], ei[t], em[t]);
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      string tg;
      tg = tag;
      if (tg == "") tg = !ev[t] ? "R2" : (ei[t] ? "R5" : "R4");
      cmp_thr(t, tg, ev[t], es[t], ep[t], ei[t], em[t]);
    end
    clear_reqs();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    clear_reqs();
    bv[0] = 1; bs[0] = 16'd3; bp[0] = 32'hAAAA_0000;
    mv[1] = 1; mt[1] = 1'b1; ms[1] = 16'd2; mp[1] = 32'hBBBB_0000;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset despite requests
    for (int t = 0; t < NT; t++) cmp_thr(t, "R1", 0, '0, '0, 0, 0);
    rst_n = 1'b1;
    clear_reqs();

    // R2: idle cycle
    step("R2");
    // R4: single branch on thread 0
    bv[1] = 1; bt[1] = 0; bs[1] = 16'h0010; bp[1] = 32'h0000_4000;
    step("R4");
    // R5: violator PC passed through unchanged on thread 1
    mv[0] = 1; mt[0] = 1; ms[0] = 16'h0020; mp[0] = 32'h0000_1236;
    step("R5");
    // R3: older branch beats younger violation
    bv[0] = 1; bs[0] = 16'd5; bp[0] = 32'h100; mv[1] = 1; ms[1] = 16'd9; mp[1] = 32'h200;
    step("R3");
    // R3: older violation beats younger branch
    bv[1] = 1; bs[1] = 16'd7; bp[1] = 32'h300; mv[0] = 1; ms[0] = 16'd3; mp[0] = 32'h400;
    step("R3");
    // R6: tie, branch slot 1 with memory slot 0
    bv[1] = 1; bs[1] = 16'd4; bp[1] = 32'h500; mv[0] = 1; ms[0] = 16'd4; mp[0] = 32'h600;
    step("R6");
    // R6: tie, branch slot 0 with memory slot 1, on thread 1
    bv[0] = 1; bt[0] = 1; bs[0] = 16'd8; bp[0] = 32'h700;
    mv[1] = 1; mt[1] = 1; ms[1] = 16'd8; mp[1] = 32'h800;
    step("R6");
    // R7: two branches same age, lower slot kept
    bv[0] = 1; bs[0] = 16'd6; bp[0] = 32'h900; bv[1] = 1; bs[1] = 16'd6; bp[1] = 32'hA00;
    step("R7");
    // R8: two violations same age, higher slot kept
    mv[0] = 1; ms[0] = 16'd6; mp[0] = 32'hB00; mv[1] = 1; ms[1] = 16'd6; mp[1] = 32'hC00;
    step("R8");
    // R9: independent requests on each thread
    bv[0] = 1; bt[0] = 0; bs[0] = 16'd50; bp[0] = 32'hD00;
    mv[0] = 1; mt[0] = 1; ms[0] = 16'd1; mp[0] = 32'hE00;
    step("R9");
    // R9: all requests on thread 1, thread 0 stays idle
    bv[0] = 1; bt[0] = 1; bs[0] = 16'd2; bp[0] = 32'hF00;
    bv[1] = 1; bt[1] = 1; bs[1] = 16'd1; bp[1] = 32'hF10;
    step("R9");
    // R2: request vanishes one cycle later
    step("R2");

    // Random phase with narrow age range to provoke ties
    for (int n = 0; n < 600; n++) begin
      for (int k = 0; k < NB; k++) begin
        bv[k] = 1'($urandom_range(0, 1)); bt[k] = TW'($urandom_range(0, NT-1));
        bs[k] = SW'($urandom_range(0, 7)); bp[k] = $urandom;
      end
      for (int k = 0; k < NM; k++) begin
        mv[k] = 1'($urandom_range(0, 1)); mt[k] = TW'($urandom_range(0, NT-1));
        ms[k] = SW'($urandom_range(0, 7)); mp[k] = $urandom;
      end
      step("");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule